// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the interrupt-entry controller of an 8-bit CPU core with a 16-bit address space and a stack in page one. At each instruction boundary it chooses between a non-maskable interrupt, a software break, and a maskable level interrupt. If one is taken, it runs a fixed seven-cycle entry sequence on a simple memory bus, then hands the handler address and the updated status to the rest of the core.

The sequence has named states. `S_IDLE` waits for a boundary. `S_DUM1` and `S_DUM2` are two dummy reads at the current PC. `S_PCH`, `S_PCL` and `S_PSW` are three stack writes. `S_VLO` and `S_VHI` read the two vector bytes. The transitions are:

- `S_IDLE` moves to `S_DUM1` when a request wins arbitration at a boundary.
- Each later state moves to the next state unconditionally.
- `S_VHI` returns to `S_IDLE`.

An NMI edge latched during the first five cycles of a break or IRQ sequence redirects that same sequence to the NMI vector. An edge seen in the last two cycles stays pending and is taken at the next boundary, which comes after the first handler instruction.

Top module: `irq_entry_seq`

## Requirements
- R1: A taken request occupies exactly seven bus cycles, starting the cycle after the boundary. `done` is high only in the seventh cycle, and in that cycle `new_pc` carries the handler address formed from the two vector bytes (low byte first).
- R2: Cycles 1 and 2 are reads (`bus_we`=0) at the captured PC. Cycles 3, 4 and 5 are writes to address {8'h01, SP} of the return address high byte, its low byte, then the status, with SP decremented after each write. `sp_out` equals the entry SP minus 3 in cycle 7.
- R3: The NMI vector is read from 16'hFFFA then 16'hFFFB. The IRQ and break vector is read from 16'hFFFE then 16'hFFFF.
- R4: At a boundary, a pending or arriving NMI wins over a break, and a break wins over an IRQ. The IRQ is taken only when `p_in` bit 2 (I) is 0, so an IRQ that loses to an NMI waits while I stays set.
- R5: The pushed status is `p_in` with bit 5 set and bit 4 set for a break and clear otherwise. The pushed return address is the boundary PC plus 2 for a break and the boundary PC otherwise.
- R6: An NMI edge in cycles 1 to 5 of a break or IRQ sequence starts no new sequence. The running sequence fetches the NMI vector, and a break keeps bit 4 set and PC plus 2 on the stack.
- R7: One NMI edge is serviced once. Its request is cleared when the NMI vector fetch is committed, so a later boundary without a new edge starts nothing.
- R8: An NMI edge in cycle 6 or 7 leaves the running sequence on its own vector. No sequence starts before the next boundary, and at that boundary an NMI sequence starts.
- R9: A hijack does not consume the IRQ. With the line still high, no sequence starts while I=1, and an IRQ sequence starts once I=0.
- R10: In cycle 7, `p_out` equals the captured `p_in` with bit 2 (I) set.
- R11: `at_boundary` and request inputs have no effect while a sequence is running.
- R12: After reset the block is idle, with `bus_en`, `bus_we` and `done` low and no NMI pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| at_boundary | input | 1 | Instruction boundary strobe |
| brk_decoded | input | 1 | The instruction at this boundary is a break |
| nmi_edge | input | 1 | One-cycle pulse from the NMI edge detector |
| irq_line | input | 1 | Level interrupt request |
| pc_in | input | 16 | PC at the boundary |
| p_in | input | 8 | Status register |
| sp_in | input | 8 | Stack pointer |
| rd_data | input | 8 | Bus read data |
| bus_addr | output | 16 | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_we | output | 1 | Bus write enable |
| bus_en | output | 1 | Bus cycle active |
| sp_out | output | 8 | Stack pointer after pushes |
| p_out | output | 8 | Status with I set, valid with done |
| new_pc | output | 16 | Handler address, valid with done |
| done | output | 1 | Entry complete strobe |

## Verification
The bench places NMI edges on both sides of the hijack window: in cycles 1 and 5, where the vector must switch, and in cycle 6, where it must not. A design with the window off by one cycle fetches the wrong vector in one of these cases. After a late edge, the bench holds off boundaries to show that nothing starts early, then checks that exactly one NMI entry follows. A design that failed to retire the request would start again at a quiet boundary, and one that dropped it would never start. The bench also holds the IRQ line high through a hijack and toggles I to show that the IRQ survives, and it checks that a hijacked break still pushes bit 4 and PC plus 2.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_DUM1, S_DUM2, S_PCH, S_PCL, S_PSW, S_VLO, S_VHI
    } seq_state_t;

    typedef enum logic [1:0] {
        K_NONE, K_NMI, K_IRQ, K_BRK
    } int_kind_t;

    localparam int FLAG_I = 2;
    localparam int FLAG_B = 4;
    localparam int FLAG_U = 5;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_edge,
    input  logic commit,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (commit)
            pend <= 1'b0;
        else if (nmi_edge)
            pend <= 1'b1;
    end

    // R7: a latched request is held until its vector fetch is committed
    p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !commit) |=> pend);
endmodule

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
    import irq_seq_pkg::*;
(
    input  logic      nmi_req,
    input  logic      brk_req,
    input  logic      irq_req,
    input  logic      i_mask,
    output int_kind_t kind,
    output logic      take
);
    always_comb begin
        if (nmi_req)
            kind = K_NMI;
        else if (brk_req)
            kind = K_BRK;
        else if (irq_req && !i_mask)
            kind = K_IRQ;
        else
            kind = K_NONE;
        take = (kind != K_NONE);
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int              AW      = 16,
    parameter int              DW      = 8,
    parameter int              BRK_ADV = 2,
    parameter logic [AW-1:0]   NMI_VEC = 16'hFFFA,
    parameter logic [AW-1:0]   IRQ_VEC = 16'hFFFE,
    parameter logic [AW-DW-1:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          at_boundary,
    input  logic          brk_decoded,
    input  logic          nmi_edge,
    input  logic          irq_line,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [DW-1:0] sp_in,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          bus_we,
    output logic          bus_en,
    output logic [DW-1:0] sp_out,
    output logic [DW-1:0] p_out,
    output logic [AW-1:0] new_pc,
    output logic          done
);
    localparam int HI_W = AW - DW;

    seq_state_t state_q, state_d;
    int_kind_t  kind_q, arb_kind;
    logic       arb_take, start, nmi_pend, nmi_req, commit, vec_nmi_q;
    logic [AW-1:0] pc_q, push_pc_q, vec_base;
    logic [DW-1:0] p_q, sp_q, vlo_q, p_push;

    assign nmi_req = nmi_pend | nmi_edge;

    irq_entry_arb i_arb (
        .nmi_req (nmi_req),
        .brk_req (brk_decoded),
        .irq_req (irq_line),
        .i_mask  (p_in[FLAG_I]),
        .kind    (arb_kind),
        .take    (arb_take)
    );

    assign start  = (state_q == S_IDLE) && at_boundary && arb_take;
    assign commit = (start && arb_kind == K_NMI) ||
                    (state_q == S_PSW && !vec_nmi_q && nmi_req);

    irq_nmi_latch i_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_edge (nmi_edge),
        .commit   (commit),
        .pend     (nmi_pend)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  state_d = start ? S_DUM1 : S_IDLE;
            S_DUM1:  state_d = S_DUM2;
            S_DUM2:  state_d = S_PCH;
            S_PCH:   state_d = S_PCL;
            S_PCL:   state_d = S_PSW;
            S_PSW:   state_d = S_VLO;
            S_VLO:   state_d = S_VHI;
            S_VHI:   state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // captured context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q    <= K_NONE;
            pc_q      <= '0;
            push_pc_q <= '0;
            p_q       <= '0;
            sp_q      <= '0;
            vlo_q     <= '0;
            vec_nmi_q <= 1'b0;
        end else if (start) begin
            kind_q    <= arb_kind;
            pc_q      <= pc_in;
            push_pc_q <= (arb_kind == K_BRK) ? pc_in + AW'(BRK_ADV) : pc_in;
            p_q       <= p_in;
            sp_q      <= sp_in;
            vec_nmi_q <= (arb_kind == K_NMI);
        end else begin
            unique case (state_q)
                S_PCH, S_PCL: sp_q <= sp_q - 1'b1;
                S_PSW: begin
                    sp_q      <= sp_q - 1'b1;
                    vec_nmi_q <= vec_nmi_q | nmi_req;
                end
                S_VLO:   vlo_q <= rd_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        p_push         = p_q;
        p_push[FLAG_U] = 1'b1;
        p_push[FLAG_B] = (kind_q == K_BRK);
        vec_base       = vec_nmi_q ? NMI_VEC : IRQ_VEC;
    end

    // outputs
    always_comb begin
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        bus_en    = 1'b1;
        new_pc    = '0;
        done      = 1'b0;
        sp_out    = sp_q;
        p_out     = p_q;
        p_out[FLAG_I] = 1'b1;
        unique case (state_q)
            S_IDLE: bus_en = 1'b0;
            S_DUM1, S_DUM2: bus_addr = pc_q;
            S_PCH: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = push_pc_q[AW-1:DW];
                bus_we    = 1'b1;
            end
            S_PCL: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = push_pc_q[DW-1:0];
                bus_we    = 1'b1;
            end
            S_PSW: begin
                bus_addr  = {STACK_PAGE, sp_q};
                bus_wdata = p_push;
                bus_we    = 1'b1;
            end
            S_VLO: bus_addr = vec_base;
            S_VHI: begin
                bus_addr = vec_base | AW'(1);
                new_pc   = {rd_data[HI_W-1:0], vlo_q};
                done     = 1'b1;
            end
            default: bus_en = 1'b0;
        endcase
    end

    // R1: the last cycle is reached exactly six cycles after the first
    p_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VHI) |-> ($past(state_q, 6) == S_DUM1));
    // R1: done is a single-cycle strobe
    p_done_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: every write lands in the stack page
    p_push_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> (bus_addr[AW-1:DW] == STACK_PAGE));
    // R4: an NMI request at a boundary starts an NMI-vectored sequence
    p_nmi_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && at_boundary && nmi_req) |=> (state_q == S_DUM1 && vec_nmi_q));
    // R6: a request latched before the commit cycle redirects the vector
    p_hijack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PSW && nmi_pend) |=> vec_nmi_q);
    // R10: status handed back has I set
    p_iflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> p_out[FLAG_I]);
    // R11: a sequence only begins from idle
    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DUM1) |-> ($past(state_q) == S_IDLE));
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
    localparam int CLK_PERIOD = 10;
    localparam int ORG_NMI = 0;
    localparam int ORG_IRQ = 1;
    localparam int ORG_BRK = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        at_boundary = 1'b0, brk_decoded = 1'b0, nmi_edge = 1'b0, irq_line = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  p_in = '0, sp_in = '0, rd_data;
    logic [15:0] bus_addr, new_pc;
    logic [7:0]  bus_wdata, sp_out, p_out;
    logic        bus_we, bus_en, done;

    int total = 0;
    int bad = 0;
    int bus_cycles = 0;

    typedef struct {
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wd;
        logic        dn;
        logic [15:0] npc;
        logic [7:0]  sp;
        logic [7:0]  p;
        string       tag;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .at_boundary(at_boundary), .brk_decoded(brk_decoded),
        .nmi_edge(nmi_edge), .irq_line(irq_line), .pc_in(pc_in), .p_in(p_in),
        .sp_in(sp_in), .rd_data(rd_data), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_en(bus_en), .sp_out(sp_out), .p_out(p_out),
        .new_pc(new_pc), .done(done)
    );

    // memory model: vectors NMI=16'h1234, IRQ/BRK=16'h5678
    always_comb begin
        case (bus_addr)
            16'hFFFA: rd_data = 8'h34;
            16'hFFFB: rd_data = 8'h12;
            16'hFFFE: rd_data = 8'h78;
            16'hFFFF: rd_data = 8'h56;
            default:  rd_data = bus_addr[7:0] ^ 8'h5A;
        endcase
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected bus items and compares
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_en) bus_cycles++;
            if (bus_en) begin
                if (q.size() == 0) begin
                    chk("R11 unexpected bus cycle", {bus_we, bus_addr}, 32'h0);
                    chk("R11 unexpected bus cycle (en)", 32'(bus_en), 32'h0);
                end else begin
                    e = q.pop_front();
                    chk({e.tag, " addr"}, 32'(bus_addr), 32'(e.addr));
                    chk({e.tag, " we"}, 32'(bus_we), 32'(e.we));
                    if (e.we) chk({e.tag, " wdata"}, 32'(bus_wdata), 32'(e.wd));
                    chk({e.tag, " done R1"}, 32'(done), 32'(e.dn));
                    if (e.dn) begin
                        chk({e.tag, " new_pc R1"}, 32'(new_pc), 32'(e.npc));
                        chk({e.tag, " sp_out R2"}, 32'(sp_out), 32'(e.sp));
                        chk({e.tag, " p_out R10"}, 32'(p_out), 32'(e.p));
                    end
                end
            end else if (done) begin
                chk("R1 done without bus cycle", 32'(done), 32'h0);
            end
        end
    end

    task automatic push_exp(input logic [15:0] a, input logic w, input logic [7:0] d,
                            input logic dn, input logic [15:0] npc, input logic [7:0] sp,
                            input logic [7:0] p, input string tag);
        exp_t x;
        x.addr = a; x.we = w; x.wd = d; x.dn = dn; x.npc = npc; x.sp = sp; x.p = p; x.tag = tag;
        q.push_back(x);
    endtask

    // driver: origin kind, context, cycle of an NMI edge (-1 none, 0 at boundary, 1..7 in sequence)
    task automatic run_entry(input string tag, input int origin, input logic [15:0] pc,
                             input logic [7:0] p, input logic [7:0] sp, input logic irq,
                             input int nmi_at, input bit poke);
        logic        use_nmi;
        logic [15:0] ppc, vec;
        logic [7:0]  pp;
        use_nmi = (origin == ORG_NMI) || (nmi_at >= 1 && nmi_at <= 5);
        vec     = use_nmi ? 16'hFFFA : 16'hFFFE;
        ppc     = (origin == ORG_BRK) ? pc + 16'd2 : pc;
        pp      = p | 8'h20;
        pp[4]   = (origin == ORG_BRK);
        push_exp(pc, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c1 R2"});
        push_exp(pc, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c2 R2"});
        push_exp({8'h01, sp}, 1'b1, ppc[15:8], 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c3 pch R5"});
        push_exp({8'h01, sp - 8'd1}, 1'b1, ppc[7:0], 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c4 pcl R5"});
        push_exp({8'h01, sp - 8'd2}, 1'b1, pp, 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c5 status R5"});
        push_exp(vec, 1'b0, 8'h00, 1'b0, 16'h0, 8'h0, 8'h0, {tag, " c6 vector R3"});
        push_exp(vec + 16'd1, 1'b0, 8'h00, 1'b1, use_nmi ? 16'h1234 : 16'h5678,
                 sp - 8'd3, p | 8'h04, {tag, " c7 vector R3"});
        @(posedge clk); #1;
        at_boundary = 1'b1;
        brk_decoded = (origin == ORG_BRK);
        irq_line    = irq;
        pc_in = pc; p_in = p; sp_in = sp;
        nmi_edge    = (nmi_at == 0);
        for (int k = 1; k <= 7; k++) begin
            @(posedge clk); #1;
            at_boundary = poke && (k == 3);
            brk_decoded = poke && (k == 3);
            nmi_edge    = (nmi_at == k);
        end
        @(posedge clk); #1;
        at_boundary = 1'b0; brk_decoded = 1'b0; nmi_edge = 1'b0;
        chk({tag, " all items seen R1"}, 32'(q.size()), 32'h0);
    endtask

    // idle check: optional boundary, then no bus activity for n cycles
    task automatic idle_check(input string tag, input int n, input bit bnd,
                              input logic [7:0] p, input logic irq);
        int start_cnt;
        start_cnt = bus_cycles;
        @(posedge clk); #1;
        p_in = p; irq_line = irq; at_boundary = bnd;
        @(posedge clk); #1;
        at_boundary = 1'b0;
        repeat (n) @(posedge clk);
        #1;
        chk(tag, 32'(bus_cycles - start_cnt), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R12 reset bus_en", 32'(bus_en), 32'h0);
        chk("R12 reset bus_we", 32'(bus_we), 32'h0);
        chk("R12 reset done", 32'(done), 32'h0);
        rst_n = 1'b1;
        // R12: a boundary with no request after reset starts nothing
        idle_check("R12 no pending NMI after reset", 4, 1'b1, 8'h04, 1'b0);

        // R1 R2 R3: plain IRQ
        run_entry("R1 plain irq", ORG_IRQ, 16'h8000, 8'h00, 8'hFD, 1'b1, -1, 1'b0);
        irq_line = 1'b0;
        // R3: plain NMI at boundary
        run_entry("R3 plain nmi", ORG_NMI, 16'h9ABC, 8'h81, 8'hF0, 1'b0, 0, 1'b0);
        // R7: the serviced edge is gone
        idle_check("R7 nmi serviced once", 4, 1'b1, 8'h04, 1'b0);
        // R4: NMI and IRQ together, NMI wins
        run_entry("R4 nmi over irq", ORG_NMI, 16'h4000, 8'h01, 8'hE0, 1'b1, 0, 1'b0);
        idle_check("R4 irq waits while I set", 4, 1'b1, 8'h04, 1'b1);
        irq_line = 1'b0;
        // R5: break pushes PC+2 and bit 4
        run_entry("R5 brk", ORG_BRK, 16'hC000, 8'h04, 8'hFF, 1'b0, -1, 1'b0);
        // R4: break wins over unmasked IRQ
        run_entry("R4 brk over irq", ORG_BRK, 16'hC0FE, 8'h40, 8'h80, 1'b1, -1, 1'b0);
        irq_line = 1'b0;
        idle_check("R4 masked irq ignored", 4, 1'b1, 8'h04, 1'b1);
        irq_line = 1'b0;
        // R6: break hijacked in cycle 1
        run_entry("R6 brk hijack c1", ORG_BRK, 16'hD010, 8'h08, 8'hA0, 1'b0, 1, 1'b0);
        idle_check("R7 hijack retired nmi", 4, 1'b1, 8'h04, 1'b0);
        // R6 R9: IRQ hijacked in cycle 5, line held
        run_entry("R6 irq hijack c5", ORG_IRQ, 16'h2222, 8'h00, 8'hC0, 1'b1, 5, 1'b0);
        idle_check("R9 irq held while I set", 4, 1'b1, 8'h04, 1'b1);
        run_entry("R9 irq taken after I cleared", ORG_IRQ, 16'h3333, 8'h00, 8'hBD, 1'b1, -1, 1'b0);
        irq_line = 1'b0;
        // R8 R11: NMI in cycle 6 stays on IRQ vector; boundary poke in cycle 3 ignored
        run_entry("R8 late nmi c6", ORG_IRQ, 16'h5555, 8'h02, 8'h90, 1'b1, 6, 1'b1);
        irq_line = 1'b0;
        idle_check("R8 no start before next boundary", 5, 1'b0, 8'h04, 1'b0);
        run_entry("R8 deferred nmi", ORG_NMI, 16'h5678, 8'h04, 8'h8D, 1'b0, -1, 1'b0);
        idle_check("R7 deferred nmi serviced once", 4, 1'b1, 8'h04, 1'b0);
        // R8: NMI in cycle 7
        run_entry("R8 late nmi c7", ORG_BRK, 16'h0600, 8'h04, 8'h70, 1'b0, 7, 1'b0);
        run_entry("R8 deferred nmi c7", ORG_NMI, 16'h5678, 8'h04, 8'h6D, 1'b0, -1, 1'b0);

        repeat (3) @(posedge clk);
        chk("R1 queue drained", 32'(q.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule